// File: doc/BRIEF.md
# Depth-Cascaded Pipelined RAM Array

This block is a wide on-chip memory with one write port and one read port, built from a grid of small RAM tiles. Tiles placed next to each other make up the full data width. Rows of tiles are chained in depth to make up the full capacity. A read request does not go to one large array. Its address, its valid flag and a travelling data word move down the chain of rows. Each row that owns the address puts its own tile output in place of the travelling word. Rows are grouped in pairs, and one register stage follows each pair. Timing between tiles therefore stays short, and the tiles do not have to be placed next to each other.

Writes travel down the same register stages as reads and in the same order. Each row therefore sees requests in the order they were issued. When a read and a write to the same row reach that row on the same edge, the read sees the old contents. The read latency is a parameter. Its smallest legal value is `ceil(rows/2) + 2`. Any larger value adds plain delay stages after the chain. Capacity, data width, tile width, tile depth and write granularity are also parameters.

Top module: `cascade_ram`

## Requirements
- R1: After a synchronous active-low reset, `rd_valid` is 0 and `rd_data` is all zeros. Both stay that way until a read returns.
- R2: A read returns the most recent data written to the same address. The upper `ROW_BITS` address bits select the depth row, and the lower `log2(TILE_WORDS)` bits select the word inside the tiles. Every row can be reached.
- R3: `rd_valid` is high for exactly one cycle, `LATENCY` cycles after the cycle in which `rd_en` was high. A read may be issued every cycle, and the results come back in issue order.
- R4: In byte mode (`GRAN = GRAN_BYTE`), `wr_be[i]` enables `wr_data[8i+7:8i]`. Bytes whose enable is 0 keep their old value.
- R5: In lane mode (`GRAN = GRAN_LANE`), a 64-bit lane `j` (bits `64j+63:64j`) is written whole when any of `wr_be[8j+7:8j]` is set. It is left untouched otherwise.
- R6: A read and a write to the same address in the same cycle return the old data. A read issued one cycle later returns the new data.
- R7: `rd_data` holds its last returned value in every cycle in which `rd_valid` is 0.
- R8: A `LATENCY` above the minimum delays `rd_valid` and `rd_data` by the extra cycles and changes nothing else. The build is refused if the latency is below the minimum, if the capacity is not a whole number of tile rows, or if there are fewer than two rows.
- R9: A cycle with `wr_en` low changes no stored data, whatever `wr_be`, `wr_addr` and `wr_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| wr_be | input | DATA_W/8 | Byte write enables |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read word address |
| rd_valid | output | 1 | Read data valid, LATENCY cycles after rd_en |
| rd_data | output | DATA_W | Read data, held between reads |

## Verification
The bench drives two instances with the same traffic: one in byte mode at minimum latency, and one in lane mode with two extra cycles. A reference model predicts the result of every read. The stimulus reaches every row. It writes a word and reads another row in the same cycle, reads the same address in the same cycle as a write and again on the next cycle, and issues back-to-back reads in reverse row order. Each of these is aimed at a specific fault:

- A row decoded from the wrong address bits returns another row's word.
- A chain that lets a write overtake a read returns new data where old data is due.
- A mismatched pipeline register moves `rd_valid` off its cycle or swaps results between rows.
- Granularity mixed up between the two modes corrupts the partly enabled lanes.
- An output that reloads while idle, or a write that ignores `wr_en`, changes data the bench compares every cycle.

// File: rtl/cascade_ram_pkg.sv
// Shared types and helpers for the depth-cascaded RAM array.
package cascade_ram_pkg;

    // Write enable granularity of each tile lane.
    typedef enum logic {
        GRAN_LANE = 1'b0,
        GRAN_BYTE = 1'b1
    } wr_gran_e;

    // Smallest read latency: input stage, one stage per row pair, output stage.
    function automatic int unsigned min_latency(input int unsigned rows);
        return (rows + 1) / 2 + 2;
    endfunction

endpackage

// File: rtl/cascade_ram_tile.sv
// One RAM tile: TILE_W bits by TILE_WORDS words, registered read, byte writes.
// Assumes: a read and a write to the same word on one edge return the old word.
module cascade_ram_tile #(
    parameter int unsigned TILE_W     = 64,
    parameter int unsigned TILE_WORDS = 64,
    localparam int unsigned TBE_W     = TILE_W / 8,
    localparam int unsigned WORD_BITS = $clog2(TILE_WORDS)
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [TBE_W-1:0]     wr_be,
    input  logic [WORD_BITS-1:0] wr_word,
    input  logic [TILE_W-1:0]    wr_data,
    input  logic [WORD_BITS-1:0] rd_word,
    output logic [TILE_W-1:0]    rd_data
);

    logic [TILE_W-1:0] mem [TILE_WORDS];

    // Byte-masked write and read-first registered read.
    always_ff @(posedge clk) begin
        for (int b = 0; b < int'(TBE_W); b++) begin
            if (wr_en && wr_be[b]) begin
                mem[wr_word][b*8 +: 8] <= wr_data[b*8 +: 8];
            end
        end
        rd_data <= mem[rd_word];
    end

endmodule

// File: rtl/cascade_ram_row.sv
// One depth row: DATA_W/TILE_W tiles side by side sharing one word address.
// Assumes: the caller qualifies wr_en with the row decode.
module cascade_ram_row
    import cascade_ram_pkg::*;
#(
    parameter int unsigned DATA_W     = 512,
    parameter int unsigned TILE_W     = 64,
    parameter int unsigned TILE_WORDS = 64,
    parameter wr_gran_e    GRAN       = GRAN_BYTE,
    localparam int unsigned BE_W      = DATA_W / 8,
    localparam int unsigned COLS      = DATA_W / TILE_W,
    localparam int unsigned TBE_W     = TILE_W / 8,
    localparam int unsigned WORD_BITS = $clog2(TILE_WORDS)
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [BE_W-1:0]      wr_be,
    input  logic [WORD_BITS-1:0] wr_word,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [WORD_BITS-1:0] rd_word,
    output logic [DATA_W-1:0]    rd_data
);

    for (genvar c = 0; c < int'(COLS); c++) begin : g_col
        logic [TBE_W-1:0] lane_be;

        if (GRAN == GRAN_BYTE) begin : g_byte
            // Byte mode: the enables pass straight to the tile.
            assign lane_be = wr_be[c*TBE_W +: TBE_W];
        end else begin : g_lane
            // Lane mode: any enable in the lane writes the whole lane.
            assign lane_be = {TBE_W{|wr_be[c*TBE_W +: TBE_W]}};
        end

        cascade_ram_tile #(
            .TILE_W     (TILE_W),
            .TILE_WORDS (TILE_WORDS)
        ) i_tile (
            .clk     (clk),
            .wr_en   (wr_en),
            .wr_be   (lane_be),
            .wr_word (wr_word),
            .wr_data (wr_data[c*TILE_W +: TILE_W]),
            .rd_word (rd_word),
            .rd_data (rd_data[c*TILE_W +: TILE_W])
        );
    end

endmodule

// File: rtl/cascade_ram_seg.sv
// One chain segment: up to two rows plus the register stage behind them.
// Replaces the travelling read word with a row's output when that row owns
// the read address. Otherwise the incoming word passes through after one cycle.
// Assumes: the inputs are the registered stage outputs of the previous segment.
module cascade_ram_seg
    import cascade_ram_pkg::*;
#(
    parameter int unsigned DATA_W     = 512,
    parameter int unsigned TILE_W     = 64,
    parameter int unsigned TILE_WORDS = 64,
    parameter int unsigned ROW_BITS   = 2,
    parameter int unsigned FIRST_ROW  = 0,
    parameter int unsigned NROWS      = 2,
    parameter wr_gran_e    GRAN       = GRAN_BYTE,
    localparam int unsigned BE_W      = DATA_W / 8,
    localparam int unsigned WORD_BITS = $clog2(TILE_WORDS),
    localparam int unsigned ADDR_W    = ROW_BITS + WORD_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_vld,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] pass_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BE_W-1:0]   wr_be,
    output logic [DATA_W-1:0] pass_out
);

    logic [NROWS-1:0]  hit;
    logic [NROWS-1:0]  hit_q;
    logic [DATA_W-1:0] pass_q;
    logic [DATA_W-1:0] row_rd [NROWS];

    for (genvar r = 0; r < int'(NROWS); r++) begin : g_row
        localparam logic [ROW_BITS-1:0] ROW_ID = ROW_BITS'(FIRST_ROW + r);
        logic row_wr;

        assign hit[r]  = rd_vld && (rd_addr[ADDR_W-1 -: ROW_BITS] == ROW_ID);
        assign row_wr  = wr_en && (wr_addr[ADDR_W-1 -: ROW_BITS] == ROW_ID);

        cascade_ram_row #(
            .DATA_W     (DATA_W),
            .TILE_W     (TILE_W),
            .TILE_WORDS (TILE_WORDS),
            .GRAN       (GRAN)
        ) i_row (
            .clk     (clk),
            .wr_en   (row_wr),
            .wr_be   (wr_be),
            .wr_word (wr_addr[WORD_BITS-1:0]),
            .wr_data (wr_data),
            .rd_word (rd_addr[WORD_BITS-1:0]),
            .rd_data (row_rd[r])
        );
    end

    // Row hit flags, aligned with the registered tile outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= '0;
        end else begin
            hit_q <= hit;
        end
    end

    // Pipeline register for the word coming from earlier rows.
    always_ff @(posedge clk) begin
        pass_q <= pass_in;
    end

    // Substitute the owning row's output for the travelling word.
    always_comb begin
        pass_out = pass_q;
        for (int r = 0; r < int'(NROWS); r++) begin
            if (hit_q[r]) begin
                pass_out = row_rd[r];
            end
        end
    end

endmodule

// File: rtl/cascade_ram.sv
// Depth-cascaded pipelined RAM array (top). Reads and writes enter one input
// register, then pass through one segment per row pair, then an output
// register, then LATENCY minus the minimum extra delay stages.
// Assumes: TILE_WORDS is a power of two, and CAPACITY_BYTES is a whole
// number of tile rows, with at least two rows.
module cascade_ram
    import cascade_ram_pkg::*;
#(
    parameter int unsigned CAPACITY_BYTES = 16384,
    parameter int unsigned DATA_W         = 512,
    parameter int unsigned TILE_W         = 64,
    parameter int unsigned TILE_WORDS     = 64,
    parameter int unsigned LATENCY        = 4,
    parameter wr_gran_e    GRAN           = GRAN_BYTE,
    localparam int unsigned BE_W          = DATA_W / 8,
    localparam int unsigned ROW_BYTES     = TILE_WORDS * BE_W,
    localparam int unsigned ROWS          = CAPACITY_BYTES / ROW_BYTES,
    localparam int unsigned ROW_BITS      = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int unsigned WORD_BITS     = $clog2(TILE_WORDS),
    localparam int unsigned ADDR_W        = ROW_BITS + WORD_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BE_W-1:0]   wr_be,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned NSEG    = (ROWS + 1) / 2;
    localparam int unsigned MIN_LAT = min_latency(ROWS);
    localparam int unsigned EXTRA   = (LATENCY > MIN_LAT) ? LATENCY - MIN_LAT : 0;

    // Elaboration checks on the configuration.
    if (ROWS < 2 || CAPACITY_BYTES % ROW_BYTES != 0) begin : g_bad_capacity
        $error("capacity must be a whole number (>= 2) of tile rows");
    end
    if (DATA_W % TILE_W != 0 || TILE_W % 8 != 0) begin : g_bad_width
        $error("data width must be whole tiles of whole bytes");
    end
    if ((1 << WORD_BITS) != TILE_WORDS) begin : g_bad_depth
        $error("tile depth must be a power of two");
    end
    if (LATENCY < MIN_LAT) begin : g_bad_latency
        $error("latency below the minimum for this row count");
    end

    logic              p_vld   [NSEG+1];
    logic [ADDR_W-1:0] p_raddr [NSEG];
    logic              p_wen   [NSEG];
    logic [ADDR_W-1:0] p_waddr [NSEG];
    logic [DATA_W-1:0] p_wdata [NSEG];
    logic [BE_W-1:0]   p_wbe   [NSEG];
    logic [DATA_W-1:0] seg_out [NSEG];
    logic              out_vld;
    logic [DATA_W-1:0] out_data;

    // Control pipeline: request flags from the input register down the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s <= int'(NSEG); s++) p_vld[s] <= 1'b0;
            for (int s = 0; s < int'(NSEG); s++)  p_wen[s] <= 1'b0;
        end else begin
            p_vld[0] <= rd_en;
            p_wen[0] <= wr_en;
            for (int s = 1; s <= int'(NSEG); s++) p_vld[s] <= p_vld[s-1];
            for (int s = 1; s < int'(NSEG); s++)  p_wen[s] <= p_wen[s-1];
        end
    end

    // Address and write-data pipeline, kept in step with the control flags.
    always_ff @(posedge clk) begin
        p_raddr[0] <= rd_addr;
        p_waddr[0] <= wr_addr;
        p_wdata[0] <= wr_data;
        p_wbe[0]   <= wr_be;
        for (int s = 1; s < int'(NSEG); s++) begin
            p_raddr[s] <= p_raddr[s-1];
            p_waddr[s] <= p_waddr[s-1];
            p_wdata[s] <= p_wdata[s-1];
            p_wbe[s]   <= p_wbe[s-1];
        end
    end

    for (genvar s = 0; s < int'(NSEG); s++) begin : g_seg
        logic [DATA_W-1:0] seg_in;

        if (s == 0) begin : g_head
            assign seg_in = '0;
        end else begin : g_link
            assign seg_in = seg_out[s-1];
        end

        cascade_ram_seg #(
            .DATA_W     (DATA_W),
            .TILE_W     (TILE_W),
            .TILE_WORDS (TILE_WORDS),
            .ROW_BITS   (ROW_BITS),
            .FIRST_ROW  (2 * s),
            .NROWS      ((2 * s + 1 < ROWS) ? 2 : 1),
            .GRAN       (GRAN)
        ) i_seg (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_vld   (p_vld[s]),
            .rd_addr  (p_raddr[s]),
            .pass_in  (seg_in),
            .wr_en    (p_wen[s]),
            .wr_addr  (p_waddr[s]),
            .wr_data  (p_wdata[s]),
            .wr_be    (p_wbe[s]),
            .pass_out (seg_out[s])
        );
    end

    // Output register: loads only on a returning read, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_data <= '0;
        end else begin
            out_vld <= p_vld[NSEG];
            if (p_vld[NSEG]) out_data <= seg_out[NSEG-1];
        end
    end

    if (EXTRA == 0) begin : g_no_delay
        assign rd_valid = out_vld;
        assign rd_data  = out_data;
    end else begin : g_delay
        logic              dl_vld  [EXTRA];
        logic [DATA_W-1:0] dl_data [EXTRA];

        // Extra latency stages; data moves only together with a valid flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 0; k < int'(EXTRA); k++) begin
                    dl_vld[k]  <= 1'b0;
                    dl_data[k] <= '0;
                end
            end else begin
                dl_vld[0] <= out_vld;
                if (out_vld) dl_data[0] <= out_data;
                for (int k = 1; k < int'(EXTRA); k++) begin
                    dl_vld[k] <= dl_vld[k-1];
                    if (dl_vld[k-1]) dl_data[k] <= dl_data[k-1];
                end
            end
        end

        assign rd_valid = dl_vld[EXTRA-1];
        assign rd_data  = dl_data[EXTRA-1];
    end

endmodule

// File: rtl/cascade_ram_chk.sv
// Checker for cascade_ram: read-valid timing, quiet start and output hold.
// Assumes: bound to every cascade_ram instance and LATENCY >= 2.
module cascade_ram_chk #(
    parameter int unsigned LATENCY = 4,
    parameter int unsigned DATA_W  = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data
);

    logic [LATENCY-1:0] req_sh;
    int unsigned        since_rst;

    // Track requests LATENCY cycles back and the cycles since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_sh    <= '0;
            since_rst <= 0;
        end else begin
            req_sh <= {req_sh[LATENCY-2:0], rd_en};
            if (since_rst < LATENCY) since_rst <= since_rst + 1;
        end
    end

    // R3 / R8: valid exactly LATENCY cycles after each request.
    assert_valid_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == req_sh[LATENCY-1]);

    // R1: no valid before a read could possibly have returned.
    assert_quiet_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < LATENCY) |-> !rd_valid);

    // R1: data stays zero until the first read returns.
    assert_zero_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < LATENCY) |-> (rd_data == '0));

    // R7: data holds while valid is low.
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rd_data));

endmodule

bind cascade_ram cascade_ram_chk #(
    .LATENCY (LATENCY),
    .DATA_W  (DATA_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
);

// File: tb/test_cascade_ram.sv
`timescale 1ns/1ps
// Bench for cascade_ram: instance A is byte mode at minimum latency,
// instance B is lane mode with two extra cycles. Both get the same stimulus.
module test_cascade_ram;
    import cascade_ram_pkg::*;

    localparam int LAT_A = 4;
    localparam int LAT_B = 6;
    localparam int LATS [2] = '{LAT_A, LAT_B};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [7:0]   wr_addr = '0;
    logic [511:0] wr_data = '0;
    logic [63:0]  wr_be = '0;
    logic         rd_en = 1'b0;
    logic [7:0]   rd_addr = '0;
    logic         vv [2];
    logic [511:0] dd [2];

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [511:0] ref_a [256];
    logic [511:0] ref_b [256];
    logic [511:0] q_d [2][$];
    int           q_t [2][$];
    string        q_g [2][$];
    logic [511:0] last [2];

    cascade_ram i_cascade_ram (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(vv[0]), .rd_data(dd[0])
    );

    cascade_ram #(.LATENCY(LAT_B), .GRAN(GRAN_LANE)) i_cascade_ram_lane (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(vv[1]), .rd_data(dd[1])
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct packed {
        logic        we;
        logic        re;
        logic [7:0]  wa;
        logic [7:0]  ra;
        logic [63:0] be;
        logic [7:0]  seed;
        logic [3:0]  tag;
    } vec_t;

    localparam logic [63:0] ALL = {64{1'b1}};
    localparam logic [63:0] PART = 64'h8000_00FF_000F_00F3;
    localparam int NVEC = 17;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b0, 8'h00, 8'h00, ALL,  8'd1, 4'd2},
        '{1'b1, 1'b0, 8'h45, 8'h00, ALL,  8'd2, 4'd2},
        '{1'b1, 1'b0, 8'hBF, 8'h00, ALL,  8'd3, 4'd2},
        '{1'b1, 1'b1, 8'hD1, 8'h00, ALL,  8'd4, 4'd2},
        '{1'b0, 1'b1, 8'h00, 8'h45, ALL,  8'd0, 4'd2},
        '{1'b0, 1'b1, 8'h00, 8'hBF, ALL,  8'd0, 4'd2},
        '{1'b0, 1'b1, 8'h00, 8'hD1, ALL,  8'd0, 4'd2},
        '{1'b1, 1'b0, 8'h00, 8'h00, PART, 8'd5, 4'd4},
        '{1'b0, 1'b1, 8'h00, 8'h00, ALL,  8'd0, 4'd4},
        '{1'b1, 1'b1, 8'hBF, 8'hBF, ALL,  8'd6, 4'd6},
        '{1'b0, 1'b1, 8'h00, 8'hBF, ALL,  8'd0, 4'd6},
        '{1'b0, 1'b1, 8'h00, 8'hD1, ALL,  8'd0, 4'd3},
        '{1'b0, 1'b1, 8'h00, 8'hBF, ALL,  8'd0, 4'd3},
        '{1'b0, 1'b1, 8'h00, 8'h45, ALL,  8'd0, 4'd3},
        '{1'b0, 1'b1, 8'h00, 8'h00, ALL,  8'd0, 4'd3},
        '{1'b1, 1'b1, 8'h7F, 8'hD1, ALL,  8'd7, 4'd2},
        '{1'b0, 1'b1, 8'h00, 8'h7F, ALL,  8'd0, 4'd2}
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd3:    return "R3";
            4'd4:    return "R4 R5";
            4'd6:    return "R6";
            default: return "R2";
        endcase
    endfunction

    function automatic logic [511:0] mkdata(input logic [7:0] seed);
        logic [511:0] d;
        for (int j = 0; j < 8; j++) begin
            d[j*64 +: 64] = {seed, 8'(j), ~seed, 8'hC3, 32'(seed) * 32'h9E37_79B1 + 32'(j)};
        end
        return d;
    endfunction

    task automatic chk(input bit ok, input string tag, input int inst,
                       input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s inst=%0d actual=%h expected=%h", tag, inst, act, exp);
        end
    endtask

    // Drive one cycle of stimulus and update both reference models.
    task automatic step(input logic we, input logic re, input logic [7:0] wa,
                        input logic [7:0] ra, input logic [63:0] be,
                        input logic [511:0] wd, input string tag);
        wr_en = we; wr_addr = wa; wr_data = wd; wr_be = be;
        rd_en = re; rd_addr = ra;
        if (re) begin
            q_d[0].push_back(ref_a[ra]); q_t[0].push_back(cyc); q_g[0].push_back(tag);
            q_d[1].push_back(ref_b[ra]); q_t[1].push_back(cyc); q_g[1].push_back(tag);
        end
        if (we) begin
            for (int b = 0; b < 64; b++) begin
                if (be[b]) ref_a[wa][b*8 +: 8] = wd[b*8 +: 8];
            end
            for (int j = 0; j < 8; j++) begin
                if (|be[j*8 +: 8]) ref_b[wa][j*64 +: 64] = wd[j*64 +: 64];
            end
        end
        @(negedge clk);
    endtask

    // Monitor: compare every returned read, its cycle, and idle hold (R7).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < 2; i++) begin
                if (vv[i]) begin
                    if (q_d[i].size() == 0) begin
                        chk(1'b0, "R3", i, 512'(1), 512'(0));
                    end else begin
                        int t;
                        logic [511:0] e;
                        string g;
                        t = q_t[i].pop_front();
                        e = q_d[i].pop_front();
                        g = q_g[i].pop_front();
                        chk(cyc == t + LATS[i], (i == 0) ? "R3" : "R8", i,
                            512'(cyc), 512'(t + LATS[i]));
                        chk(dd[i] == e, g, i, dd[i], e);
                        last[i] = dd[i];
                    end
                end else begin
                    chk(dd[i] == last[i], "R7", i, dd[i], last[i]);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 256; a++) begin
            ref_a[a] = '0;
            ref_b[a] = '0;
        end
        last[0] = '0;
        last[1] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state on both instances.
        for (int i = 0; i < 2; i++) begin
            chk(vv[i] == 1'b0, "R1", i, 512'(vv[i]), 512'(0));
            chk(dd[i] == '0, "R1", i, dd[i], '0);
        end
        rst_n = 1'b1;

        // Table walk: rows, byte/lane masks, same-cycle hazard, back-to-back.
        for (int n = 0; n < NVEC; n++) begin
            step(VEC[n].we, VEC[n].re, VEC[n].wa, VEC[n].ra, VEC[n].be,
                 mkdata(VEC[n].seed), tag_name(VEC[n].tag));
        end
        for (int n = 0; n < 10; n++) step(1'b0, 1'b0, '0, '0, '0, '0, "R7");

        // R9: wr_en low with every enable set must not touch address 0x45.
        step(1'b0, 1'b0, 8'h45, 8'h00, ALL, mkdata(8'd9), "R9");
        step(1'b0, 1'b1, 8'h00, 8'h45, '0, '0, "R9");
        // R7: long idle after the last read; the monitor checks the hold.
        for (int n = 0; n < 15; n++) step(1'b0, 1'b0, '0, '0, '0, '0, "R7");

        // R3: every issued read came back.
        for (int i = 0; i < 2; i++) begin
            chk(q_d[i].size() == 0, "R3", i, 512'(q_d[i].size()), 512'(0));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule